// File: doc/BRIEF.md
# Coalescing Transactional Store Buffer

This block holds speculative 64-bit stores away from memory until software-visible state is either made permanent or thrown away. Each entry is keyed by a doubleword address, meaning a byte address with its three low bits removed. A store to a doubleword that already has an entry is merged into that entry, byte by byte. A store to a new doubleword takes the next free slot. Every entry is also tagged with one of 16 sets, found by hashing the doubleword address. A lookup only considers the entries that belong to the matching set.

Loads look up the buffer combinationally. The word the memory returns on the read side channel is combined with whatever bytes the buffer holds for that doubleword. A commit strobe drains every entry, oldest allocation first, through a valid/ready memory write port, then empties the buffer. A rollback strobe empties the buffer at once and writes nothing.

Top module: `txn_store_buffer`

## Requirements
- R1: After a synchronous active-low reset, the buffer is empty, and `busy`, `mem_wr_valid`, `st_full`, `st_err` and `commit_done` are all low.
- R2: The set index is the XOR of all 4-bit groups of the doubleword address, with the top group zero-padded. Two different addresses that share a set are kept as separate entries and never alias each other.
- R3: A store to an address with no entry fills the next slot in allocation order. The stored word keeps the store's bytes where the mask is set and holds zero in every other byte. Mask bit i covers data bits 8i+7 down to 8i.
- R4: A store to an address that already has an entry replaces only the bytes its mask selects, and ORs its mask into the entry's mask.
- R5: A load to an address with no entry returns `mem_rd_data` unchanged, in the same cycle.
- R6: A load that hits returns the buffered byte wherever the entry mask bit is set and the `mem_rd_data` byte wherever it is clear. With a full mask of 0xFF this is the buffered word.
- R7: On commit, the block presents each entry in allocation order on `mem_wr_valid`/`mem_wr_addr`/`mem_wr_data`/`mem_wr_mask`, and holds each one until a cycle in which `mem_wr_ready` is high.
- R8: `commit_done` pulses for one cycle, in the cycle after the last write is accepted, and the buffer is empty from then on. A commit on an empty buffer gives `commit_done` in the next cycle and no writes.
- R9: `busy` is high while a drain is in progress. Stores, commits and rollbacks presented while busy have no effect.
- R10: Rollback empties the buffer and produces no memory write. When strobes arrive in the same idle cycle, rollback wins over commit, and commit wins over a store; the losing requests are dropped.
- R11: `st_full` is high while all DEPTH slots are in use. A store to a new address while full is refused and `st_err` pulses in the next cycle. A store that hits an existing entry still merges while full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request strobe |
| st_dw_addr | input | DW | Store doubleword address |
| st_data | input | 64 | Store data |
| st_mask | input | 8 | Store byte enables |
| st_full | output | 1 | All slots occupied |
| st_err | output | 1 | One-cycle pulse: a store to a new address was refused |
| ld_dw_addr | input | DW | Load doubleword address; memory reads the same address |
| mem_rd_data | input | 64 | Word read from memory for ld_dw_addr |
| ld_data | output | 64 | Merged load result, valid while busy is low |
| commit | input | 1 | Commit strobe |
| rollback | input | 1 | Rollback strobe |
| busy | output | 1 | Drain in progress; request ports stalled |
| commit_done | output | 1 | One-cycle pulse when a commit has finished |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_addr | output | DW | Memory write doubleword address |
| mem_wr_data | output | 64 | Memory write data |
| mem_wr_mask | output | 8 | Memory write byte enables |
| mem_wr_ready | input | 1 | Memory accepts the write |

## Verification
The bench builds the block with DEPTH=4 and DW=13. The small depth means a handful of stores fills the buffer, so the refused-store and merge-while-full corners come up early. The 13-bit address leaves room to choose doublewords 0x001 and 0x010, which fold to the same set and so exercise the collision rule. While the buffer drains, the ready line follows an irregular pattern, so each write has to be held across stalled cycles, and `commit_done` has to follow the final accepted write rather than any earlier one.

// File: rtl/tsb_pkg.sv
// Package: shared constants and byte-merge helpers for the store buffer.
// Assumes 64-bit data words with one mask bit per byte.
package tsb_pkg;
    localparam int TSB_SETS   = 16;
    localparam int TSB_SET_W  = 4;
    localparam int TSB_DATA_W = 64;
    localparam int TSB_MASK_W = TSB_DATA_W / 8;

    // Widen a byte mask into a bit mask.
    function automatic logic [TSB_DATA_W-1:0] tsb_expand(input logic [TSB_MASK_W-1:0] m);
        logic [TSB_DATA_W-1:0] r;
        for (int i = 0; i < TSB_MASK_W; i++) r[8*i +: 8] = {8{m[i]}};
        return r;
    endfunction

    // Take bytes of nw where m is set, bytes of old elsewhere.
    function automatic logic [TSB_DATA_W-1:0] tsb_merge(input logic [TSB_DATA_W-1:0] old,
                                                        input logic [TSB_DATA_W-1:0] nw,
                                                        input logic [TSB_MASK_W-1:0] m);
        logic [TSB_DATA_W-1:0] e;
        e = tsb_expand(m);
        return (old & ~e) | (nw & e);
    endfunction
endpackage

// File: rtl/tsb_set_hash.sv
// Module: folds a doubleword address to a 4-bit set index by XORing
// its 4-bit groups. Assumes the top group is zero-padded when DW is
// not a multiple of four. Purely combinational.
module tsb_set_hash
    import tsb_pkg::*;
#(
    parameter int DW = 29
) (
    input  logic [DW-1:0]        dw_addr,
    output logic [TSB_SET_W-1:0] set_idx
);
    localparam int NG = (DW + TSB_SET_W - 1) / TSB_SET_W;
    localparam int PW = NG * TSB_SET_W;

    logic [PW-1:0]        padded;
    logic [TSB_SET_W-1:0] acc [NG+1];

    // Zero-extend so every group is full width.
    assign padded = PW'(dw_addr);
    assign acc[0] = '0;

    // Chain of XORs, one stage per group.
    for (genvar g = 0; g < NG; g++) begin : g_fold
        assign acc[g+1] = acc[g] ^ padded[TSB_SET_W*g +: TSB_SET_W];
    end

    assign set_idx = acc[NG];
endmodule

// File: rtl/tsb_drain_ctrl.sv
// Module: commit drain sequencer. Steps a read pointer through slots
// 0..count-1, advancing only on accepted writes, then raises a done
// pulse. Assumes count is stable while busy (the top stalls stores).
module tsb_drain_ctrl #(
    parameter int IW = 5,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] count,
    input  logic          wr_ready,
    output logic          busy,
    output logic [IW-1:0] ptr,
    output logic          last_accept,
    output logic          done
);
    // Final write of the drain is being accepted this cycle.
    assign last_accept = busy && wr_ready && (CW'(ptr) == count - CW'(1));

    // Drain state, pointer and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            ptr  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (last_accept) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else if (wr_ready) begin
                    ptr <= ptr + IW'(1);
                end
            end else if (start) begin
                if (count == '0) begin
                    done <= 1'b1;
                end else begin
                    busy <= 1'b1;
                    ptr  <= '0;
                end
            end
        end
    end

    // R8
    // done_idle_chk
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    // ptr_hold_chk
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_ready) |=> (busy && $stable(ptr)));
endmodule

// File: rtl/txn_store_buffer.sv
// Module: coalescing transactional store buffer. Stores are buffered
// per doubleword and merged by byte mask; loads merge buffered bytes
// with memory data; commit drains in allocation order; rollback discards.
// Assumes DEPTH >= 2 and that mem_rd_data answers ld_dw_addr in-cycle.
module txn_store_buffer
    import tsb_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 29
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  st_valid,
    input  logic [DW-1:0]         st_dw_addr,
    input  logic [TSB_DATA_W-1:0] st_data,
    input  logic [TSB_MASK_W-1:0] st_mask,
    output logic                  st_full,
    output logic                  st_err,
    input  logic [DW-1:0]         ld_dw_addr,
    input  logic [TSB_DATA_W-1:0] mem_rd_data,
    output logic [TSB_DATA_W-1:0] ld_data,
    input  logic                  commit,
    input  logic                  rollback,
    output logic                  busy,
    output logic                  commit_done,
    output logic                  mem_wr_valid,
    output logic [DW-1:0]         mem_wr_addr,
    output logic [TSB_DATA_W-1:0] mem_wr_data,
    output logic [TSB_MASK_W-1:0] mem_wr_mask,
    input  logic                  mem_wr_ready
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0]         e_addr  [DEPTH];
    logic [TSB_DATA_W-1:0] e_data  [DEPTH];
    logic [TSB_MASK_W-1:0] e_mask  [DEPTH];
    logic [DEPTH-1:0]      set_mem [TSB_SETS];
    logic [CW-1:0]         count;

    logic [TSB_SET_W-1:0]  st_set, ld_set;
    logic [DEPTH-1:0]      st_hitv, ld_hitv;
    logic                  st_hit, ld_hit;
    logic [IW-1:0]         st_slot, ld_slot, rd_ptr;
    logic                  drain_start, drain_last, idle;

    tsb_set_hash #(.DW(DW)) st_hash_i (.dw_addr(st_dw_addr), .set_idx(st_set));
    tsb_set_hash #(.DW(DW)) ld_hash_i (.dw_addr(ld_dw_addr), .set_idx(ld_set));

    assign idle        = !busy;
    assign drain_start = idle && commit && !rollback;
    assign st_full     = (count == CW'(DEPTH));

    tsb_drain_ctrl #(.IW(IW), .CW(CW)) drain_i (
        .clk(clk), .rst_n(rst_n), .start(drain_start), .count(count),
        .wr_ready(mem_wr_ready), .busy(busy), .ptr(rd_ptr),
        .last_accept(drain_last), .done(commit_done)
    );

    // Match vectors: entry is in the addressed set and its tag is equal.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            st_hitv[i] = set_mem[st_set][i] && (e_addr[i] == st_dw_addr);
            ld_hitv[i] = set_mem[ld_set][i] && (e_addr[i] == ld_dw_addr);
        end
    end

    // Encode the matching slot of each port.
    always_comb begin
        st_hit = 1'b0; st_slot = '0;
        ld_hit = 1'b0; ld_slot = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_hitv[i]) begin st_hit = 1'b1; st_slot = IW'(i); end
            if (ld_hitv[i]) begin ld_hit = 1'b1; ld_slot = IW'(i); end
        end
    end

    // Load result: buffered bytes over memory bytes.
    always_comb begin
        ld_data = mem_rd_data;
        if (ld_hit) ld_data = tsb_merge(mem_rd_data, e_data[ld_slot], e_mask[ld_slot]);
    end

    // Write port shows the entry under the drain pointer.
    assign mem_wr_valid = busy;
    assign mem_wr_addr  = e_addr[rd_ptr];
    assign mem_wr_data  = e_data[rd_ptr];
    assign mem_wr_mask  = e_mask[rd_ptr];

    // Entry storage, set membership, count and refusal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            st_err <= 1'b0;
            for (int s = 0; s < TSB_SETS; s++) set_mem[s] <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                e_addr[i] <= '0;
                e_data[i] <= '0;
                e_mask[i] <= '0;
            end
        end else begin
            st_err <= 1'b0;
            if (drain_last || (idle && rollback)) begin
                count <= '0;
                for (int s = 0; s < TSB_SETS; s++) set_mem[s] <= '0;
            end else if (idle && !commit && st_valid) begin
                if (st_hit) begin
                    e_data[st_slot] <= tsb_merge(e_data[st_slot], st_data, st_mask);
                    e_mask[st_slot] <= e_mask[st_slot] | st_mask;
                end else if (!st_full) begin
                    e_addr[count[IW-1:0]] <= st_dw_addr;
                    e_data[count[IW-1:0]] <= st_data & tsb_expand(st_mask);
                    e_mask[count[IW-1:0]] <= st_mask;
                    set_mem[st_set][count[IW-1:0]] <= 1'b1;
                    count <= count + CW'(1);
                end else begin
                    st_err <= 1'b1;
                end
            end
        end
    end

    // R11
    // count_bound_chk
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R11
    // err_when_full_chk
    err_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_err |-> $past(st_full));

    // R2
    // single_match_chk
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_hitv) && $onehot0(ld_hitv));

    // R7
    // wr_hold_chk
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=>
        (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data) && $stable(mem_wr_mask)));

    // R10
    // rollback_empty_chk
    rollback_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && rollback) |=> (count == '0 && !mem_wr_valid));
endmodule

// File: tb/txn_store_buffer_tb_top.sv
module txn_store_buffer_tb_top;
    localparam int DEPTH = 4;
    localparam int DW    = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic [DW-1:0] st_dw_addr = '0;
    logic [63:0]   st_data = '0;
    logic [7:0]    st_mask = '0;
    logic          st_full, st_err;
    logic [DW-1:0] ld_dw_addr = '0;
    logic [63:0]   mem_rd_data = '0;
    logic [63:0]   ld_data;
    logic          commit = 1'b0, rollback = 1'b0;
    logic          busy, commit_done;
    logic          mem_wr_valid;
    logic [DW-1:0] mem_wr_addr;
    logic [63:0]   mem_wr_data;
    logic [7:0]    mem_wr_mask;
    logic          mem_wr_ready = 1'b0;

    always #5 clk = ~clk;

    txn_store_buffer #(.DEPTH(DEPTH), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_dw_addr(st_dw_addr),
        .st_data(st_data), .st_mask(st_mask), .st_full(st_full), .st_err(st_err),
        .ld_dw_addr(ld_dw_addr), .mem_rd_data(mem_rd_data), .ld_data(ld_data),
        .commit(commit), .rollback(rollback), .busy(busy), .commit_done(commit_done),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_mask(mem_wr_mask), .mem_wr_ready(mem_wr_ready)
    );

    // Reference model state: allocation-ordered queues.
    int          qa[$];
    logic [63:0] qd[$];
    logic [7:0]  qm[$];
    bit          m_busy, m_err, m_done;
    int          m_ptr;
    int          vectors = 0, fails = 0;
    bit          finished = 0;

    function automatic logic [63:0] expand(input logic [7:0] m);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = {8{m[i]}};
        return r;
    endfunction

    function automatic int find(input int a);
        for (int i = 0; i < qa.size(); i++) if (qa[i] == a) return i;
        return -1;
    endfunction

    // Model update at each rising edge, from the inputs held there.
    always @(posedge clk) begin
        m_err = 0; m_done = 0;
        if (!rst_n) begin
            qa.delete(); qd.delete(); qm.delete(); m_busy = 0; m_ptr = 0;
        end else if (m_busy) begin
            if (mem_wr_ready) begin
                m_ptr++;
                if (m_ptr == qa.size()) begin
                    qa.delete(); qd.delete(); qm.delete(); m_busy = 0; m_done = 1;
                end
            end
        end else if (rollback) begin
            qa.delete(); qd.delete(); qm.delete();
        end else if (commit) begin
            if (qa.size() == 0) m_done = 1;
            else begin m_busy = 1; m_ptr = 0; end
        end else if (st_valid) begin
            int k;
            k = find(int'(st_dw_addr));
            if (k >= 0) begin
                qd[k] = (qd[k] & ~expand(st_mask)) | (st_data & expand(st_mask));
                qm[k] = qm[k] | st_mask;
            end else if (qa.size() < DEPTH) begin
                qa.push_back(int'(st_dw_addr));
                qd.push_back(st_data & expand(st_mask));
                qm.push_back(st_mask);
            end else m_err = 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output against the model.
    task automatic compare();
        int k;
        logic [63:0] e;
        chk("R11 st_full", 64'(st_full), 64'(qa.size() == DEPTH));
        chk("R11 st_err", 64'(st_err), 64'(m_err));
        chk("R9 busy", 64'(busy), 64'(m_busy));
        chk("R8 commit_done", 64'(commit_done), 64'(m_done));
        chk("R7 mem_wr_valid", 64'(mem_wr_valid), 64'(m_busy));
        if (m_busy) begin
            chk("R7 mem_wr_addr", 64'(mem_wr_addr), 64'(qa[m_ptr]));
            chk("R7 mem_wr_data", mem_wr_data, qd[m_ptr]);
            chk("R7 mem_wr_mask", 64'(mem_wr_mask), 64'(qm[m_ptr]));
        end else begin
            k = find(int'(ld_dw_addr));
            if (k < 0) chk("R5 ld_data miss", ld_data, mem_rd_data);
            else begin
                e = (mem_rd_data & ~expand(qm[k])) | (qd[k] & expand(qm[k]));
                chk("R6 ld_data hit", ld_data, e);
            end
        end
    endtask

    int cyc = 0;
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
        cyc++;
        mem_rd_data = {32'hA5C3_0000 + 32'(cyc), 32'h1E2D_0000 ^ 32'(cyc * 7)};
        #1;
        if (rst_n) compare();
    endtask

    task automatic store(input int a, input logic [63:0] d, input logic [7:0] m);
        st_valid = 1; st_dw_addr = DW'(a); st_data = d; st_mask = m;
        tick();
        st_valid = 0;
    endtask

    task automatic look(input int a);
        ld_dw_addr = DW'(a);
        tick();
    endtask

    task automatic drain();
        int n = 0;
        commit = 1; tick(); commit = 0;
        while (busy && n < 100) begin
            mem_wr_ready = (n % 3) != 1;
            st_valid = (n % 2) == 0; st_dw_addr = DW'(5); st_data = '1; st_mask = 8'hFF;
            rollback = (n == 2);   // R9: ignored while busy
            tick();
            n++;
        end
        st_valid = 0; rollback = 0; mem_wr_ready = 0;
        tick();
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1: reset state
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 mem_wr_valid", 64'(mem_wr_valid), 64'd0);
        chk("R1 st_full", 64'(st_full), 64'd0);
        chk("R1 commit_done", 64'(commit_done), 64'd0);
        // R3: allocation with partial mask, then R6 partial merge on load
        store(1, 64'h1122_3344_5566_7788, 8'h0F);
        look(1);
        // R4: merge upper bytes into same entry
        store(1, 64'h99AA_BBCC_DDEE_FF00, 8'hF0);
        look(1);
        store(1, 64'h0000_0000_0000_00EE, 8'h01);
        look(1);
        // R2: 0x010 folds to the same set as 0x001
        store(16, 64'hCAFE_F00D_DEAD_BEEF, 8'hFF);
        look(16); look(1);
        // R5: miss
        look(2);
        store(12'h123, 64'h0102_0304_0506_0708, 8'h3C);
        store(13'h1FFF, 64'hFFFF_0000_FFFF_0000, 8'hC3);
        // R11: full, refused, then merge while full
        store(7, 64'h7777_7777_7777_7777, 8'hFF);
        look(7);
        store(16, 64'h0, 8'h80);
        look(16);
        // R7 R8 R9: drain with irregular ready
        drain();
        look(1); look(16);
        // R10: rollback discards without writes
        store(3, 64'h3333_3333_3333_3333, 8'hFF);
        store(4, 64'h4444_4444_4444_4444, 8'h0F);
        rollback = 1; commit = 1; st_valid = 1; st_dw_addr = DW'(9); st_mask = 8'hFF;
        tick();
        rollback = 0; commit = 0; st_valid = 0;
        look(3); look(9); tick();
        // R8: empty commit
        commit = 1; tick(); commit = 0; tick();
        // R10: commit beats store in the same cycle
        store(6, 64'h6666_0000_6666_0000, 8'hAA);
        commit = 1; st_valid = 1; st_dw_addr = DW'(8); st_mask = 8'hFF;
        tick();
        commit = 0; st_valid = 0;
        mem_wr_ready = 1;
        repeat (3) tick();
        mem_wr_ready = 0;
        look(8); look(6);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule